// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. The 16-bit counter is outside the block. The channel works in one of two modes, output compare or input capture, and both modes use a single register that software can read and write.

In output-compare mode a software write lands in a staging register. The value moves into the live compare register straight away or at the next update pulse; a buffering-enable input chooses which. When the counter first equals the live compare value, the channel output gives a one-clock pulse and a sticky match flag is set.

In input-capture mode the channel watches an asynchronous pin through a two-flop synchronizer. Each rising edge copies the counter into the shared register and sets a sticky capture flag. A capture that arrives while the capture flag is still set also raises an overcapture flag, and the newer value replaces the older one. Software writes are dropped in this mode.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset, rd_data_o is 0, the live compare value is 0, and match_o, match_flag_o, cap_flag_o and ovr_flag_o are all 0.
- R2: With mode_cap_i=0 and preload_en_i=0, a write (wr_en_i=1) updates both the staging register and the live compare register on the same clock edge.
- R3: With mode_cap_i=0 and preload_en_i=1, a write updates only the staging register. The live compare register copies the staging value at the edge where update_i=1. If a write and update_i=1 arrive in the same cycle, the live register takes the newly written value.
- R4: With mode_cap_i=0, rd_data_o returns the staging register and not the live compare register.
- R5: With mode_cap_i=0, match_o is high for exactly one cycle. That cycle follows the edge at which cnt_i first equals the live compare value. It does not repeat while the equality persists.
- R6: match_flag_o is set on the edge that raises match_o. It is cleared by match_clr_i=1. If set and clear happen in the same cycle, the set wins.
- R7: With mode_cap_i=1, a rising edge on cap_pin_i is synchronized by two flops. cnt_i is captured into the register at the third rising clock edge after the pin rises, provided the pin meets setup before the first of those edges.
- R8: Each capture sets cap_flag_o. cap_clr_i=1 clears both cap_flag_o and ovr_flag_o, and a simultaneous set wins.
- R9: A capture that occurs while cap_flag_o=1 sets ovr_flag_o and overwrites the register with the new count.
- R10: With mode_cap_i=1, software writes have no effect on the register.
- R11: With mode_cap_i=0, edges on cap_pin_i change neither the register nor the capture flags. With mode_cap_i=1, match_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_cap_i | input | 1 | 0 = output compare, 1 = input capture |
| preload_en_i | input | 1 | 1 = buffered transfer on update, 0 = immediate |
| update_i | input | 1 | One-cycle update event pulse |
| cnt_i | input | 16 | Timer counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data |
| cap_pin_i | input | 1 | Asynchronous capture input |
| match_clr_i | input | 1 | Clear match flag |
| cap_clr_i | input | 1 | Clear capture and overcapture flags |
| match_o | output | 1 | One-cycle compare match pulse |
| match_flag_o | output | 1 | Sticky match flag |
| cap_flag_o | output | 1 | Sticky capture flag |
| ovr_flag_o | output | 1 | Sticky overcapture flag |

## Verification
Writes, flag clears and update-driven transfers show at the ports one edge after the stimulus. A match pulse shows one edge after the counter is driven to the compare value. A capture shows three edges after the pin rises. The bench drives every input on the falling clock edge and then counts exactly that many rising edges before it samples on a later falling edge. For captures it checks the capture flag after two edges (still clear) and after three (set). It also changes the counter on each of those cycles, so a capture taken one cycle early or late shows a different value. The live compare value cannot be read directly, so the bench observes it through match pulses.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  typedef enum logic {
    CC_MODE_OUT = 1'b0,
    CC_MODE_IN  = 1'b1
  } cc_mode_e;

  typedef struct packed {
    logic cap;
    logic ovr;
  } cc_capflags_t;
endpackage

// File: rtl/tmr_cc_edge_sync.sv
module tmr_cc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  localparam int LAST = STAGES;

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
  logic [LAST:0] chain_q;

  for (genvar g = 0; g <= LAST; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];
endmodule

// File: rtl/tmr_cc_store.sv
module tmr_cc_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_out_i,
  input  logic             preload_en_i,
  input  logic             update_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             cap_evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] ccr_o,
  output logic [CNT_W-1:0] active_o
);
  logic [CNT_W-1:0] ccr_q, ccr_d, active_q;
  logic             sw_wr;

  assign sw_wr = wr_en_i & mode_out_i;

  always_comb begin
    ccr_d = ccr_q;
    if (cap_evt_i)  ccr_d = cnt_i;
    else if (sw_wr) ccr_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ccr_q <= '0;
    else         ccr_q <= ccr_d;
  end

  // immediate path bypasses staging; buffered path takes the post-write staging value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  active_q <= '0;
    else if (sw_wr && !preload_en_i)              active_q <= wr_data_i;
    else if (mode_out_i && preload_en_i && update_i) active_q <= ccr_d;
  end

  assign ccr_o    = ccr_q;
  assign active_o = active_q;
endmodule

// File: rtl/tmr_cc_match.sv
module tmr_cc_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_out_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] active_i,
  input  logic             clr_i,
  output logic             match_o,
  output logic             flag_o
);
  logic eq, eq_prev_q, hit, match_q, flag_q;

  assign eq  = mode_out_i && (cnt_i == active_i);
  assign hit = eq & ~eq_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_prev_q <= 1'b0;
      match_q   <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      eq_prev_q <= eq;
      match_q   <= hit;
      if (hit)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign match_o = match_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_cap_i,
  input  logic             preload_en_i,
  input  logic             update_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             cap_pin_i,
  input  logic             match_clr_i,
  input  logic             cap_clr_i,
  output logic             match_o,
  output logic             match_flag_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o
);
  import tmr_cc_pkg::*;

  cc_mode_e         mode;
  logic             mode_out, pin_rise, cap_evt;
  logic [CNT_W-1:0] active_val;
  cc_capflags_t     cflags_q;

  assign mode     = cc_mode_e'(mode_cap_i);
  assign mode_out = (mode == CC_MODE_OUT);

  tmr_cc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cap_pin_i),
    .rise_o(pin_rise)
  );

  assign cap_evt = pin_rise & (mode == CC_MODE_IN);

  tmr_cc_store #(.CNT_W(CNT_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_out_i  (mode_out),
    .preload_en_i(preload_en_i),
    .update_i    (update_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cap_evt_i   (cap_evt),
    .cnt_i       (cnt_i),
    .ccr_o       (rd_data_o),
    .active_o    (active_val)
  );

  tmr_cc_match #(.CNT_W(CNT_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_out_i(mode_out),
    .cnt_i     (cnt_i),
    .active_i  (active_val),
    .clr_i     (match_clr_i),
    .match_o   (match_o),
    .flag_o    (match_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cflags_q <= '0;
    end else if (cap_evt) begin
      cflags_q.cap <= 1'b1;
      if (cflags_q.cap) cflags_q.ovr <= 1'b1;
    end else if (cap_clr_i) begin
      cflags_q <= '0;
    end
  end

  assign cap_flag_o = cflags_q.cap;
  assign ovr_flag_o = cflags_q.ovr;
endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_cap_i,
  input logic             preload_en_i,
  input logic             update_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic [CNT_W-1:0] active_val,
  input logic             cap_evt,
  input logic             match_o,
  input logic             match_flag_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o
);
  AST_IMM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_cap_i && !preload_en_i) |=>
      (active_val == $past(wr_data_i)) && (rd_data_o == $past(wr_data_i))); // R2

  AST_PRELOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && !update_i) |=> $stable(active_val)); // R3

  AST_PRELOAD_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preload_en_i && update_i && !mode_cap_i && !wr_en_i) |=> (active_val == $past(rd_data_o))); // R3

  AST_MATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o); // R5

  AST_MATCH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> match_flag_o); // R6

  AST_OVERCAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt && cap_flag_o) |=> ovr_flag_o); // R9

  AST_IN_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_cap_i && wr_en_i && !cap_evt) |=> $stable(rd_data_o)); // R10

  AST_NO_MATCH_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_cap_i |=> !match_o); // R11
endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_cap_i  (mode_cap_i),
  .preload_en_i(preload_en_i),
  .update_i    (update_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .active_val  (active_val),
  .cap_evt     (cap_evt),
  .match_o     (match_o),
  .match_flag_o(match_flag_o),
  .cap_flag_o  (cap_flag_o),
  .ovr_flag_o  (ovr_flag_o)
);

// File: tb/tmr_cc_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_cc_channel_tb_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_cap_i = 1'b0, preload_en_i = 1'b0, update_i = 1'b0;
  logic [W-1:0] cnt_i = 16'h1234;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic         cap_pin_i = 1'b0, match_clr_i = 1'b0, cap_clr_i = 1'b0;
  logic         match_o, match_flag_o, cap_flag_o, ovr_flag_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  tmr_cc_channel dut_i (
    .clk_i, .rst_ni, .mode_cap_i, .preload_en_i, .update_i, .cnt_i,
    .wr_en_i, .wr_data_i, .rd_data_o, .cap_pin_i, .match_clr_i, .cap_clr_i,
    .match_o, .match_flag_o, .cap_flag_o, .ovr_flag_o
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic sw_write(input logic [W-1:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data_o, 16'h0);
    chk("R1 match", {15'b0, match_o}, 16'h0);
    chk("R1 flags", {13'b0, match_flag_o, cap_flag_o, ovr_flag_o}, 16'h0);
    cnt_i = 16'h0000; step();
    chk("R1 live value zero -> match", {15'b0, match_o}, 16'h1);
    match_clr_i = 1'b1; cnt_i = 16'h0001; step(); match_clr_i = 1'b0;
  endtask

  task automatic t_immediate();
    preload_en_i = 1'b0; mode_cap_i = 1'b0;
    sw_write(16'h0040);
    chk("R2 rd after write", rd_data_o, 16'h0040);
    chk("R5 no match off value", {15'b0, match_o}, 16'h0);
    cnt_i = 16'h0040; step();
    chk("R2/R5 match pulse", {15'b0, match_o}, 16'h1);
    chk("R6 flag set", {15'b0, match_flag_o}, 16'h1);
    step();
    chk("R5 no repeat while equal", {15'b0, match_o}, 16'h0);
    cnt_i = 16'h0041; step();
    chk("R6 flag sticky", {15'b0, match_flag_o}, 16'h1);
    match_clr_i = 1'b1; step(); match_clr_i = 1'b0;
    chk("R6 flag cleared", {15'b0, match_flag_o}, 16'h0);
    cnt_i = 16'h0040; match_clr_i = 1'b1; step(); match_clr_i = 1'b0;
    chk("R6 set wins over clear", {15'b0, match_flag_o}, 16'h1);
    cnt_i = 16'h0000; match_clr_i = 1'b1; step(); match_clr_i = 1'b0;
  endtask

  task automatic t_preload();
    preload_en_i = 1'b1;
    sw_write(16'h0100);
    chk("R4 rd returns staging", rd_data_o, 16'h0100);
    cnt_i = 16'h0100; step();
    chk("R3 live not yet moved", {15'b0, match_o}, 16'h0);
    cnt_i = 16'h0040; step();
    chk("R3 live keeps old value", {15'b0, match_o}, 16'h1);
    cnt_i = 16'h0000; update_i = 1'b1; step(); update_i = 1'b0;
    cnt_i = 16'h0100; step();
    chk("R3 transfer on update", {15'b0, match_o}, 16'h1);
    cnt_i = 16'h0000;
    wr_en_i = 1'b1; wr_data_i = 16'h0200; update_i = 1'b1; step();
    wr_en_i = 1'b0; update_i = 1'b0;
    cnt_i = 16'h0200; step();
    chk("R3 same-cycle write+update", {15'b0, match_o}, 16'h1);
    cnt_i = 16'h0000; match_clr_i = 1'b1; step(); match_clr_i = 1'b0;
    preload_en_i = 1'b0;
  endtask

  task automatic t_capture();
    mode_cap_i = 1'b1;
    cap_pin_i = 1'b1; cnt_i = 16'h0700; step();
    cnt_i = 16'h0701; step();
    chk("R7 no capture after two edges", {15'b0, cap_flag_o}, 16'h0);
    cnt_i = 16'h0702; step();
    chk("R7/R8 flag after third edge", {15'b0, cap_flag_o}, 16'h1);
    chk("R7 captured count", rd_data_o, 16'h0702);
    chk("R9 no overcapture yet", {15'b0, ovr_flag_o}, 16'h0);
    cap_pin_i = 1'b0; step(3);
    sw_write(16'hBEEF);
    chk("R10 write ignored", rd_data_o, 16'h0702);
    cnt_i = 16'h0900; cap_pin_i = 1'b1; step(3);
    chk("R9 overwrite", rd_data_o, 16'h0900);
    chk("R9 overcapture set", {15'b0, ovr_flag_o}, 16'h1);
    cap_pin_i = 1'b0; step(3);
    cap_clr_i = 1'b1; step(); cap_clr_i = 1'b0;
    chk("R8 clear both flags", {14'b0, cap_flag_o, ovr_flag_o}, 16'h0);
  endtask

  task automatic t_cross();
    mode_cap_i = 1'b0; preload_en_i = 1'b0;
    sw_write(16'h0055);
    cnt_i = 16'h0300; cap_pin_i = 1'b1; step(4); cap_pin_i = 1'b0; step(3);
    chk("R11 pin ignored: register", rd_data_o, 16'h0055);
    chk("R11 pin ignored: flag", {15'b0, cap_flag_o}, 16'h0);
    mode_cap_i = 1'b1; cnt_i = 16'h0055; step();
    chk("R11 no match in capture mode", {15'b0, match_o}, 16'h0);
    step();
    chk("R11 no match flag in capture mode", {15'b0, match_flag_o}, 16'h0);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_immediate();
    t_preload();
    t_capture();
    t_cross();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule